// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the timing enables for a UART. It turns a 16-bit integer divisor and a 4-bit fraction in sixteenths into a periodic sample enable. The enable runs at 16, 8 or 4 times the bit rate. A second enable marks each bit boundary. Both enables are one input clock wide, and downstream logic uses them as clock enables.

Three byte-wide registers are written through a simple write port:

- the low divisor byte,
- the high divisor byte,
- a fraction/mode byte.

The fraction/mode byte takes a write only while the enhanced-features input is high.

The fraction works through a phase accumulator. Across every run of 16 sample periods, as many periods as the fraction value are one clock longer than the integer divisor. The longer periods are spread evenly through the run. The average sample period therefore equals the divisor plus the fraction over 16.

Top module: `fracBaudGen`

## Requirements
- R1: After reset the low byte, the high byte and the fraction/mode byte are all zero: the divisor is zero, the fraction is zero and the mode is 16x. Neither enable fires until a nonzero divisor is written.
- R2: A write with `wrSel` = 0 loads the low divisor byte, `wrSel` = 1 loads the high byte, and `wrSel` = 2 loads the fraction/mode byte. The divisor is {high, low}. A write with `wrSel` = 3 has no effect.
- R3: With the fraction at zero and a divisor D that is not zero, `sampleTick` is high for one clock in every D clocks. The first pulse comes in the D-th cycle after the accepted write edge.
- R4: With a fraction F, a 4-bit accumulator starts at 0 after each restart and adds F at every sample pulse. A sample period lasts D+1 clocks when acc+F overflows 4 bits, and D clocks otherwise. Any 16 consecutive periods from a restart therefore hold exactly F stretched periods.
- R5: Bits [5:4] of the fraction/mode byte pick the oversampling: 00 is 16x, 01 is 8x, 10 is 4x, and 11 acts as 16x. `bitTick` is high together with every N-th `sampleTick`, counting from the restart.
- R6: A write with `wrSel` = 2 while `enhEn` is low is ignored. It changes neither the fraction nor the mode, and it does not restart the counters.
- R7: While the divisor is zero, `sampleTick` and `bitTick` stay low.
- R8: Every accepted write clears the period counter, the accumulator and the sample counter, so timing restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 low byte, 1 high byte, 2 fraction/mode, 3 none |
| wrData | input | 8 | Write data; for the fraction/mode byte, bits [3:0] hold the fraction and bits [5:4] the mode |
| enhEn | input | 1 | Enhanced-features enable; gates writes to the fraction/mode byte |
| sampleTick | output | 1 | One-clock enable at the oversampling rate |
| bitTick | output | 1 | One-clock enable at the bit rate |

## Verification
A write takes effect at the clock edge that samples it. From that edge the counters count one step per clock, so the first sample pulse is due D clocks later, or D+1 if the first period is stretched. Both enables are decoded from registered state with no further delay, so each is due in the same cycle the counter reaches the end of its period. The bench keeps a cycle-accurate reference of the registers and counters, built from the requirements. It advances that reference just after every rising edge, using the inputs sampled at that edge. It compares both enables at the falling edge, before it drives the next inputs, so each comparison reads the outputs of the cycle whose state the reference holds.

// File: rtl/fbgPkg.sv
package fbgPkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_FRAC = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    OS_16  = 2'd0,
    OS_8   = 2'd1,
    OS_4   = 2'd2,
    OS_16B = 2'd3
  } osMode_e;

  typedef struct packed {
    logic restart;
  } fbgStrobe_t;

  localparam int SUB_W = 4;

  function automatic logic [SUB_W-1:0] lastSub(osMode_e m);
    case (m)
      OS_8:    return SUB_W'(7);
      OS_4:    return SUB_W'(3);
      default: return SUB_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/fbgCtrl.sv
module fbgCtrl
  import fbgPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              enhEn,
  output logic [DIV_W-1:0]  divisor,
  output logic [FRAC_W-1:0] frac,
  output osMode_e           osMode,
  output fbgStrobe_t        strobes
);
  logic [BYTE_W-1:0] loReg, hiReg;
  logic [FRAC_W+1:0] fracReg;
  logic loWr, hiWr, fracWr;

  always_comb begin
    loWr   = wrEn && (regSel_e'(wrSel) == SEL_LO);
    hiWr   = wrEn && (regSel_e'(wrSel) == SEL_HI);
    fracWr = wrEn && (regSel_e'(wrSel) == SEL_FRAC) && enhEn;
    strobes.restart = loWr || hiWr || fracWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loReg   <= '0;
      hiReg   <= '0;
      fracReg <= '0;
    end else begin
      if (loWr)   loReg   <= wrData;
      if (hiWr)   hiReg   <= wrData;
      if (fracWr) fracReg <= wrData[FRAC_W+1:0];
    end
  end

  assign divisor = {hiReg, loReg};
  assign frac    = fracReg[FRAC_W-1:0];
  assign osMode  = osMode_e'(fracReg[FRAC_W+1:FRAC_W]);

  // R6
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel_e'(wrSel) == SEL_FRAC && !enhEn) |=> $stable(fracReg));

  // R2
  null_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel_e'(wrSel) == SEL_NONE) |=> ($stable(loReg) && $stable(hiReg) && $stable(fracReg)));
endmodule

// File: rtl/fbgDatapath.sv
module fbgDatapath
  import fbgPkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbgStrobe_t        strobes,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] frac,
  input  osMode_e           osMode,
  output logic              sampleTick,
  output logic              bitTick
);
  logic [CNT_W-1:0]  cnt, periodLen;
  logic [FRAC_W:0]   accSum;
  logic [FRAC_W-1:0] acc;
  logic [SUB_W-1:0]  subCnt, subLast;
  logic divZero, periodEnd;

  always_comb begin
    accSum    = {1'b0, acc} + {1'b0, frac};
    periodLen = {1'b0, divisor} + CNT_W'(accSum[FRAC_W]);
    divZero   = (divisor == '0);
    periodEnd = !divZero && (cnt == periodLen - CNT_W'(1));
    subLast   = lastSub(osMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      acc    <= '0;
      subCnt <= '0;
    end else if (strobes.restart) begin
      cnt    <= '0;
      acc    <= '0;
      subCnt <= '0;
    end else if (!divZero) begin
      if (periodEnd) begin
        cnt    <= '0;
        acc    <= accSum[FRAC_W-1:0];
        subCnt <= (subCnt == subLast) ? '0 : subCnt + SUB_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign sampleTick = periodEnd;
  assign bitTick    = periodEnd && (subCnt == subLast);

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> (!sampleTick && !bitTick));

  // R5
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !divZero |-> (cnt < periodLen));

  // R5
  sub_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= subLast);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (cnt == '0 && acc == '0 && subCnt == '0));
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import fbgPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              enhEn,
  output logic              sampleTick,
  output logic              bitTick
);
  logic [DIV_W-1:0]  divisor;
  logic [FRAC_W-1:0] frac;
  osMode_e           osMode;
  fbgStrobe_t        strobes;

  fbgCtrl #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .enhEn(enhEn), .divisor(divisor), .frac(frac), .osMode(osMode),
    .strobes(strobes)
  );

  fbgDatapath #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divisor(divisor),
    .frac(frac), .osMode(osMode), .sampleTick(sampleTick), .bitTick(bitTick)
  );
endmodule

// File: tb/fracBaudGen_test.sv
module fracBaudGen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic enhEn = 1'b0;
  logic sampleTick, bitTick;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  // reference state
  int mLo = 0, mHi = 0, mFrac = 0, mMode = 0;
  int mCnt = 0, mAcc = 0, mSub = 0;
  int sTicks = 0, bTicks = 0;

  fracBaudGen uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .enhEn(enhEn), .sampleTick(sampleTick), .bitTick(bitTick)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ratioOf(int m);
    if (m == 1) return 8;
    if (m == 2) return 4;
    return 16;
  endfunction

  function automatic int divOf();
    return mHi * 256 + mLo;
  endfunction

  function automatic int lenOf();
    return divOf() + (((mAcc + mFrac) > 15) ? 1 : 0);
  endfunction

  function automatic bit expSample();
    return (divOf() != 0) && (mCnt == lenOf() - 1);
  endfunction

  function automatic bit expBit();
    return expSample() && (mSub == ratioOf(mMode) - 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // advance reference model using inputs sampled at the edge just passed
  task automatic modelStep();
    bit accepted;
    accepted = wrEn && (wrSel != 2'd3) && (wrSel != 2'd2 || enhEn);
    if (accepted) begin
      case (wrSel)
        2'd0: mLo = int'(wrData);
        2'd1: mHi = int'(wrData);
        default: begin
          mFrac = int'(wrData[3:0]);
          mMode = int'(wrData[5:4]);
        end
      endcase
      mCnt = 0; mAcc = 0; mSub = 0;
    end else if (divOf() != 0) begin
      if (mCnt == lenOf() - 1) begin
        mCnt = 0;
        mAcc = (mAcc + mFrac) % 16;
        mSub = (mSub == ratioOf(mMode) - 1) ? 0 : mSub + 1;
      end else begin
        mCnt++;
      end
    end
  endtask

  // one cycle: compare at falling edge, drive, step model after rising edge
  task automatic cycle(bit we, logic [1:0] sel, logic [7:0] d, bit enh);
    @(negedge clk);
    check(curReq, "sampleTick", int'(sampleTick), int'(expSample()));
    check(curReq, "bitTick", int'(bitTick), int'(expBit()));
    if (sampleTick) sTicks++;
    if (bitTick) bTicks++;
    wrEn = we; wrSel = sel; wrData = d; enhEn = enh;
    @(posedge clk);
    #1;
    modelStep();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic setup(int div, int fr, int mode);
    cycle(1'b1, 2'd1, 8'(div >> 8), 1'b0);
    cycle(1'b1, 2'd0, 8'(div), 1'b0);
    cycle(1'b1, 2'd2, 8'((mode << 4) | fr), 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: nothing fires out of reset
    curReq = "R1";
    sTicks = 0;
    idle(40);
    check("R1", "ticks after reset", sTicks, 0);

    // R3: integer divisor 5, 16x; first tick 5 cycles after write edge
    curReq = "R3";
    setup(5, 0, 0);
    sTicks = 0; bTicks = 0;
    idle(80);
    check("R3", "sample ticks in 80 cycles", sTicks, 16);
    check("R3", "bit ticks in 80 cycles", bTicks, 1);

    // R4: divisor 3, fraction 5 -> 16 periods take 53 cycles
    curReq = "R4";
    setup(3, 5, 0);
    sTicks = 0; bTicks = 0;
    idle(53);
    check("R4", "sample ticks in 53 cycles", sTicks, 16);
    check("R4", "bit ticks in 53 cycles", bTicks, 1);
    // R4: fraction 15 with divisor 1
    setup(1, 15, 0);
    sTicks = 0;
    idle(31);
    check("R4", "sample ticks div1 frac15", sTicks, 16);

    // R5: each mode, divisor 2
    for (int m = 0; m < 4; m++) begin
      curReq = "R5";
      setup(2, 0, m);
      bTicks = 0;
      idle(64);
      check("R5", "bit ticks over 64 cycles", bTicks, 32 / ratioOf(m));
    end

    // R6: gated write does not change mode or restart
    curReq = "R6";
    setup(4, 0, 2);
    idle(6);
    cycle(1'b1, 2'd2, 8'h0F, 1'b0);
    sTicks = 0; bTicks = 0;
    idle(64);
    check("R6", "sample ticks after gated write", sTicks, 16);
    check("R6", "bit ticks after gated write", bTicks, 4);

    // R2: select 3 is a no-op, high byte placement
    curReq = "R2";
    cycle(1'b1, 2'd3, 8'hFF, 1'b1);
    idle(10);
    setup(16'h0102, 0, 0);
    sTicks = 0;
    idle(258);
    check("R2", "ticks with divisor 0x0102", sTicks, 1);

    // R7: zero divisor stops enables
    curReq = "R7";
    setup(0, 7, 1);
    sTicks = 0;
    idle(100);
    check("R7", "ticks with zero divisor", sTicks, 0);

    // R8: rewrite mid-period restarts timing
    curReq = "R8";
    setup(10, 0, 0);
    idle(7);
    cycle(1'b1, 2'd0, 8'd10, 1'b0);
    sTicks = 0;
    idle(9);
    check("R8", "no tick before restarted period ends", sTicks, 0);
    idle(1);
    check("R8", "tick at restarted period end", sTicks, 1);

    // constrained random mix (R3/R4/R5 checked cycle by cycle)
    curReq = "R4";
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind == 0) cycle(1'b1, 2'd0, 8'($urandom_range(0, 6)), 1'b0);
      else if (kind == 1) cycle(1'b1, 2'd1, 8'($urandom_range(0, 1) == 0 ? 0 : 0), 1'b0);
      else if (kind == 2) cycle(1'b1, 2'd2, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else if (kind == 3) cycle(1'b1, 2'd3, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else idle(int'($urandom_range(1, 60)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule